// File: doc/BRIEF.md
# Dual-Lane Rounding Accumulate and Pack

This block finishes a dual halfword multiply-accumulate with rounding. Two signed 32-bit products arrive side by side in one 64-bit operand. Each product is added to its own 32-bit accumulator together with a rounding bias of half a halfword step (0x8000). The sum is formed wide enough that it cannot wrap. The upper halfword of each lane sum is kept, and the two upper halfwords are packed into a single 32-bit result word.

A saturating mode clamps a lane that leaves the signed 32-bit range before its upper halfword is taken. Without it, the lane's out-of-range condition is reported but the value wraps.

The accumulators come either from two full 32-bit words or, in a packed mode, from a single 32-bit word whose two halfwords are each placed in the upper half of one accumulator. A registered strobe captures the result together with an overflow flag, an early-warning flag for results near the range edge, and sticky versions of both.

Top module: `rnd_acc_pack`

## Requirements
- R1: The low lane takes its product from `prod_pair[31:0]` and the high lane from `prod_pair[63:32]`. Both products and both accumulators are treated as signed two's-complement values.
- R2: Each lane forms accumulator + product + 0x8000 exactly, with no wrap before the range check.
- R3: `res_word[31:16]` is bits 31:16 of the high-lane result and `res_word[15:0]` is bits 31:16 of the low-lane result.
- R4: `ovf` is 1 when either lane's exact sum is above 0x7FFFFFFF or below -0x80000000, and 0 otherwise.
- R5: With `op_sat`=1, an out-of-range lane becomes 0x7FFFFFFF if its sum is positive or 0x80000000 if its sum is negative. With `op_sat`=0, the lane keeps the low 32 bits of its sum.
- R6: `adv` is the OR over both lanes of bit 31 XOR bit 30 of the unsaturated lane sum.
- R7: `ovf_sticky` and `adv_sticky` OR in `ovf` and `adv` on every strobe. They fall only on reset.
- R8: With `op_packed_acc`=1, the low accumulator is `acc_packed` shifted left by 16 and the high accumulator is `acc_packed` AND 0xFFFF0000. In this mode `acc_lo` and `acc_hi` have no effect.
- R9: The result and flags appear in the cycle after `op_valid` is sampled high, and `res_valid` pulses for that one cycle. Without a strobe, all outputs hold and `res_valid` is 0.
- R10: While reset is active, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Capture strobe for one operation |
| op_sat | input | 1 | 1 = clamp out-of-range lanes |
| op_packed_acc | input | 1 | 1 = accumulators come from `acc_packed` |
| prod_pair | input | 64 | High-lane product in 63:32, low-lane product in 31:0 |
| acc_lo | input | 32 | Low-lane accumulator (full-word mode) |
| acc_hi | input | 32 | High-lane accumulator (full-word mode) |
| acc_packed | input | 32 | Two accumulator halfwords (packed mode) |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_word | output | 32 | Packed rounded upper halfwords |
| ovf | output | 1 | Range overflow of the last operation |
| adv | output | 1 | Near-range warning of the last operation |
| ovf_sticky | output | 1 | Accumulated overflow |
| adv_sticky | output | 1 | Accumulated near-range warning |

## Verification
A wrong lane sum, a missing rounding bias or a swapped lane shows in the packed word in the cycle right after the strobe. The damage is confined to one halfword, so the bench compares each word against an exact 64-bit model. The model covers rounding ties, both clamp directions and a wrapped non-saturating result. A wrong flag register or a lost sticky bit shows on the flag ports one cycle after the offending strobe and stays visible afterwards, because the sticky flags only grow. A stuck capture enable shows either as a missing `res_valid` pulse or as an output changing on an idle cycle.

// File: rtl/rnd_acc_pack_pkg.sv
package rnd_acc_pack_pkg;
  localparam int unsigned NLANE = 2;

  typedef struct packed {
    logic ovf;
    logic adv;
  } lane_flags_t;
endpackage

// File: rtl/rap_acc_expand.sv
module rap_acc_expand #(
  parameter int unsigned W = 32
) (
  input  logic         packed_mode,
  input  logic [W-1:0] word_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] hi_in,
  output logic [W-1:0] lo_out,
  output logic [W-1:0] hi_out
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] lo_exp;
  logic [W-1:0] hi_exp;

  // Each halfword of the packed word lands in the upper half of one accumulator.
  always_comb begin
    lo_exp = {word_in[H-1:0], {H{1'b0}}};
    hi_exp = {word_in[W-1:H], {H{1'b0}}};
  end

  always_comb begin
    if (packed_mode) begin
      lo_out = lo_exp;
      hi_out = hi_exp;
    end else begin
      lo_out = lo_in;
      hi_out = hi_in;
    end
  end
endmodule

// File: rtl/rap_lane.sv
module rap_lane
  import rnd_acc_pack_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          sat_en,
  input  logic [W-1:0]  acc,
  input  logic [W-1:0]  prod,
  output logic [W/2-1:0] upper,
  output lane_flags_t   flags
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned WW = W + 2;
  localparam logic [WW-1:0] RND_BIAS = WW'(1) << (H - 1);
  localparam logic [W-1:0]  POS_MAX  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  NEG_MIN  = {1'b1, {(W-1){1'b0}}};

  logic [WW-1:0] wide;
  logic          in_range;
  logic [W-1:0]  lane_val;

  // Two guard bits keep acc + prod + bias from wrapping.
  always_comb begin
    wide = {{2{acc[W-1]}}, acc} + {{2{prod[W-1]}}, prod} + RND_BIAS;
  end

  // In range when the guard bits and the sign bit all agree.
  always_comb begin
    in_range = (wide[WW-1:W-1] == '0) || (wide[WW-1:W-1] == '1);
  end

  always_comb begin
    if (sat_en && !in_range) begin
      lane_val = wide[WW-1] ? NEG_MIN : POS_MAX;
    end else begin
      lane_val = wide[W-1:0];
    end
  end

  always_comb begin
    upper     = lane_val[W-1:H];
    flags.ovf = !in_range;
    flags.adv = wide[W-1] ^ wide[W-2];
  end
endmodule

// File: rtl/rnd_acc_pack.sv
module rnd_acc_pack
  import rnd_acc_pack_pkg::*;
#(
  parameter int unsigned LANE_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  input  logic                      op_sat,
  input  logic                      op_packed_acc,
  input  logic [NLANE*LANE_W-1:0]   prod_pair,
  input  logic [LANE_W-1:0]         acc_lo,
  input  logic [LANE_W-1:0]         acc_hi,
  input  logic [LANE_W-1:0]         acc_packed,
  output logic                      res_valid,
  output logic [LANE_W-1:0]         res_word,
  output logic                      ovf,
  output logic                      adv,
  output logic                      ovf_sticky,
  output logic                      adv_sticky
);
  localparam int unsigned H = LANE_W / 2;

  logic [LANE_W-1:0] lane_acc [NLANE];
  logic [H-1:0]      lane_up  [NLANE];
  lane_flags_t       lane_fl  [NLANE];
  logic [NLANE-1:0]  ovf_vec;
  logic [NLANE-1:0]  adv_vec;

  logic [LANE_W-1:0] word_calc;
  logic              ovf_calc;
  logic              adv_calc;

  logic              vld_d,  vld_q;
  logic [LANE_W-1:0] word_d, word_q;
  logic              ovf_d,  ovf_q;
  logic              adv_d,  adv_q;
  logic              sov_d,  sov_q;
  logic              sadv_d, sadv_q;

  rap_acc_expand #(.W(LANE_W)) u_expand (
    .packed_mode (op_packed_acc),
    .word_in     (acc_packed),
    .lo_in       (acc_lo),
    .hi_in       (acc_hi),
    .lo_out      (lane_acc[0]),
    .hi_out      (lane_acc[1])
  );

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    rap_lane #(.W(LANE_W)) u_lane (
      .sat_en (op_sat),
      .acc    (lane_acc[gi]),
      .prod   (prod_pair[gi*LANE_W +: LANE_W]),
      .upper  (lane_up[gi]),
      .flags  (lane_fl[gi])
    );
    always_comb begin
      ovf_vec[gi] = lane_fl[gi].ovf;
      adv_vec[gi] = lane_fl[gi].adv;
    end
  end

  // Lane i fills halfword i of the result.
  always_comb begin
    for (int i = 0; i < NLANE; i++) begin
      word_calc[i*H +: H] = lane_up[i];
    end
    ovf_calc = |ovf_vec;
    adv_calc = |adv_vec;
  end

  // Next-state: capture on the strobe, hold otherwise.
  always_comb begin
    vld_d  = op_valid;
    word_d = word_q;
    ovf_d  = ovf_q;
    adv_d  = adv_q;
    sov_d  = sov_q;
    sadv_d = sadv_q;
    if (op_valid) begin
      word_d = word_calc;
      ovf_d  = ovf_calc;
      adv_d  = adv_calc;
      sov_d  = sov_q | ovf_calc;
      sadv_d = sadv_q | adv_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
      ovf_q  <= 1'b0;
      adv_q  <= 1'b0;
      sov_q  <= 1'b0;
      sadv_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      word_q <= word_d;
      ovf_q  <= ovf_d;
      adv_q  <= adv_d;
      sov_q  <= sov_d;
      sadv_q <= sadv_d;
    end
  end

  always_comb begin
    res_valid  = vld_q;
    res_word   = word_q;
    ovf        = ovf_q;
    adv        = adv_q;
    ovf_sticky = sov_q;
    adv_sticky = sadv_q;
  end
endmodule

// File: rtl/rnd_acc_pack_chk.sv
module rnd_acc_pack_chk #(
  parameter int unsigned LANE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              res_valid,
  input logic [LANE_W-1:0] res_word,
  input logic              ovf,
  input logic              adv,
  input logic              ovf_sticky,
  input logic              adv_sticky
);
  // R9
  res_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(res_word) && $stable(ovf) && $stable(adv)));

  // R7
  ovf_sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ovf_sticky));

  // R7
  adv_sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(adv_sticky));

  // R4
  ovf_in_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ovf_sticky);

  // R6
  adv_in_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> adv_sticky);
endmodule

bind rnd_acc_pack rnd_acc_pack_chk #(.LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .res_valid  (res_valid),
  .res_word   (res_word),
  .ovf        (ovf),
  .adv        (adv),
  .ovf_sticky (ovf_sticky),
  .adv_sticky (adv_sticky)
);

// File: tb/rnd_acc_pack_bench.sv
module rnd_acc_pack_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic        op_sat;
  logic        op_packed_acc;
  logic [63:0] prod_pair;
  logic [31:0] acc_lo;
  logic [31:0] acc_hi;
  logic [31:0] acc_packed;
  logic        res_valid;
  logic [31:0] res_word;
  logic        ovf;
  logic        adv;
  logic        ovf_sticky;
  logic        adv_sticky;

  typedef struct {
    logic [31:0] word;
    logic        o;
    logic        a;
    logic        so;
    logic        sa;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          fails  = 0;
  logic        m_so = 1'b0;
  logic        m_sa = 1'b0;
  logic [31:0] last_word = '0;
  bit          done = 1'b0;

  rnd_acc_pack u_rnd_acc_pack (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_sat        (op_sat),
    .op_packed_acc (op_packed_acc),
    .prod_pair     (prod_pair),
    .acc_lo        (acc_lo),
    .acc_hi        (acc_hi),
    .acc_packed    (acc_packed),
    .res_valid     (res_valid),
    .res_word      (res_word),
    .ovf           (ovf),
    .adv           (adv),
    .ovf_sticky    (ovf_sticky),
    .adv_sticky    (adv_sticky)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Exact 64-bit model of one lane.
  task automatic ref_lane(input logic [31:0] acc, input logic [31:0] prod, input logic sat,
                          output logic [15:0] up, output logic o, output logic a);
    longint wide;
    logic [31:0] v;
    wide = longint'($signed(acc)) + longint'($signed(prod)) + 64'sd32768;
    o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
    a = wide[31] ^ wide[30];
    if (sat && o) v = (wide < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    else          v = wide[31:0];
    up = v[31:16];
  endtask

  task automatic send(input logic [63:0] p, input logic [31:0] al, input logic [31:0] ah,
                      input logic [31:0] pw, input logic sat, input logic pk);
    exp_t e;
    logic [31:0] el, eh;
    logic [15:0] u0, u1;
    logic o0, o1, a0, a1;
    el = pk ? {pw[15:0], 16'h0000} : al;
    eh = pk ? {pw[31:16], 16'h0000} : ah;
    ref_lane(el, p[31:0],  sat, u0, o0, a0);
    ref_lane(eh, p[63:32], sat, u1, o1, a1);
    e.word = {u1, u0};
    e.o    = o0 | o1;
    e.a    = a0 | a1;
    m_so   = m_so | e.o;
    m_sa   = m_sa | e.a;
    e.so   = m_so;
    e.sa   = m_sa;
    last_word = e.word;
    sb_q.push_back(e);
    op_valid = 1'b1; op_sat = sat; op_packed_acc = pk;
    prod_pair = p; acc_lo = al; acc_hi = ah; acc_packed = pw;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb_q.size() == 0) begin
        chk("R9 unexpected result", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R1 R2 R3 R5 R8 res_word", res_word, e.word);
        chk("R4 ovf", {31'd0, ovf}, {31'd0, e.o});
        chk("R6 adv", {31'd0, adv}, {31'd0, e.a});
        chk("R7 ovf_sticky", {31'd0, ovf_sticky}, {31'd0, e.so});
        chk("R7 adv_sticky", {31'd0, adv_sticky}, {31'd0, e.sa});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sat = 1'b0; op_packed_acc = 1'b0;
    prod_pair = '0; acc_lo = '0; acc_hi = '0; acc_packed = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R10 res_word", res_word, 32'd0);
    chk("R10 flags", {28'd0, ovf, adv, ovf_sticky, adv_sticky}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 rounding just below and at the tie, both lanes
    send({32'h0000_8000, 32'h0000_7FFF}, 32'h0001_0000, 32'h0003_0000, '0, 1'b0, 1'b0);
    // R1 lane order with distinct signed values
    send({32'hFFFF_0000, 32'h0012_3456}, 32'hFFFE_8000, 32'h1000_0000, '0, 1'b1, 1'b0);
    // R6 near-range warning without overflow
    send({32'h0000_0000, 32'h4000_0000}, 32'h0000_0000, 32'h0000_0000, '0, 1'b1, 1'b0);
    // R5 positive clamp, low lane
    send({32'h0000_0000, 32'h0001_0000}, 32'h7FFF_8000, 32'h0000_0000, '0, 1'b1, 1'b0);
    // R5 negative clamp, high lane
    send({32'h8000_0000, 32'h0000_0000}, 32'h0000_0000, 32'h8000_0000, '0, 1'b1, 1'b0);
    // R5 no clamp when not saturating (wraps)
    send({32'h8000_0000, 32'h0001_0000}, 32'h7FFF_8000, 32'h8000_0000, '0, 1'b0, 1'b0);
    // R8 packed accumulators, garbage on full-word inputs
    send({32'h0000_1234, 32'hFFFF_F000}, 32'hDEAD_BEEF, 32'h5A5A_5A5A, 32'h8001_7FFF, 1'b1, 1'b0);
    send({32'h0000_1234, 32'hFFFF_F000}, 32'hDEAD_BEEF, 32'h5A5A_5A5A, 32'h8001_7FFF, 1'b1, 1'b1);
    // R8 packed mode reaching overflow
    send({32'h8000_0000, 32'h7FFF_0000}, 32'h0, 32'h0, 32'h8000_7FFF, 1'b1, 1'b1);
    // back-to-back random operations
    for (int i = 0; i < 40; i++) begin
      send({$urandom, $urandom}, $urandom, $urandom, $urandom, 1'(i % 2), 1'(i % 3 == 0));
    end
    // R9 hold after idle cycles
    repeat (3) @(negedge clk);
    chk("R9 idle res_valid", {31'd0, res_valid}, 32'd0);
    chk("R9 idle hold", res_word, last_word);
    chk("R9 scoreboard drained", sb_q.size(), 32'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule